// File: doc/BRIEF.md
# Bus Extension Port Master

This block connects a host processor to a remote expansion bus adapter over a narrow synchronous port. For each host request it produces one cycle of a port clock. That clock is derived from the fast system clock and its low phase is much longer than its high phase. Address and output data go out ahead of the rising edge. The remote side takes the output data on the falling edge. Returned data is sampled late in the low phase, once the remote side has had time to drive it.

The host pulses a one-cycle request carrying a peripheral register number, a two-bit sub-function and a write word. The sub-function selects one of four fixed offsets in the 16-address window that belongs to each register. When the port cycle finishes, the block returns a one-cycle acknowledge and, for reads, the captured word. Phase lengths are parameters counted in system clock ticks. The defaults assume a 5 ns tick: a 25 ns lead, a 40 ns high phase and a 100 ns trailing low phase.

Top module: `bxp_master`

## Requirements
- R1: While reset is high and on the first cycle after it, bx_clk, bx_addr, bx_dout, host_ack and host_rdata are all zero.
- R2: A request is accepted on a rising system clock edge when host_req is high and no transaction is in progress. From the next cycle, bx_addr and bx_dout carry the new values and bx_clk stays low for exactly LEAD_TICKS cycles (default 5) before it rises.
- R3: bx_clk stays high for exactly HIGH_TICKS cycles (default 8). Output data has been stable for at least 36 ns when bx_clk falls.
- R4: After bx_clk falls it stays low for TRAIL_TICKS cycles (default 20, at least 90 ns). The transaction ends on the edge that closes that window. Successive rising edges of bx_clk are at least 137 ns apart.
- R5: bx_addr is the register number in the upper bits with a 4-bit offset below it. The offset depends on host_op: 0 (write low half) gives 0, 1 (write high half) gives 11, 2 (read low half) gives 9 and 3 (read high half) gives 10.
- R6: bx_addr and bx_dout do not change on any cycle where bx_clk changes or is high. Between transactions they keep the last transaction's values.
- R7: host_ack is high for exactly one cycle. It rises LEAD_TICKS+HIGH_TICKS+TRAIL_TICKS cycles after the accepting edge.
- R8: For a read (host_op bit 1 set), host_rdata presents the bx_din value sampled on the closing edge, together with host_ack. For a write, host_rdata is zero. host_rdata holds its value until the next transaction ends.
- R9: A request that arrives while a transaction is in progress is ignored. A request during the acknowledge cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick of port timing |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle request strobe |
| host_op | input | 2 | Sub-function: 0 write low, 1 write high, 2 read low, 3 read high |
| host_reg | input | REG_W | Peripheral register number |
| host_wdata | input | DATA_W | Word to drive on the port |
| host_ack | output | 1 | One-cycle completion strobe |
| host_rdata | output | DATA_W | Captured read word |
| bx_clk | output | 1 | Port clock, falling edge active |
| bx_addr | output | REG_W+4 | Port address |
| bx_dout | output | DATA_W | Port output data |
| bx_din | input | DATA_W | Port input data |

## Verification
If the phase counter or state is wrong, the fault shows on bx_clk within one cycle. A high phase or lead that is too short or too long moves the next edge, and the per-cycle comparison catches that on the very tick where the edge arrives or fails to arrive. A wrong offset or a stale address register shows on bx_addr in the cycle after acceptance. A capture on the wrong edge shows in host_rdata during the acknowledge cycle, because bx_din is changed on every tick. If the busy state is lost, a request made during a transaction is not ignored, and bx_addr changes while the port cycle is still running.

// File: rtl/bxp_pkg.sv
package bxp_pkg;

    typedef enum logic [1:0] {
        OP_WR_LO = 2'd0,
        OP_WR_HI = 2'd1,
        OP_RD_LO = 2'd2,
        OP_RD_HI = 2'd3
    } bxp_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_HIGH  = 2'd2,
        PH_TRAIL = 2'd3
    } bxp_phase_e;

    localparam int SUB_W = 4;

    // Offset inside the 16-address window of one register
    function automatic logic [SUB_W-1:0] sub_offset(bxp_op_e op);
        logic [SUB_W-1:0] off;
        case (op)
            OP_WR_LO: off = 4'd0;
            OP_WR_HI: off = 4'd11;
            OP_RD_LO: off = 4'd9;
            default:  off = 4'd10;
        endcase
        return off;
    endfunction

    function automatic logic op_is_read(bxp_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/bxp_seq.sv
module bxp_seq
    import bxp_pkg::*;
#(
    parameter int LEAD_TICKS  = 5,
    parameter int HIGH_TICKS  = 8,
    parameter int TRAIL_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       idle,
    output logic       port_clk,
    output logic       capture
);
    localparam int MAX_T = (LEAD_TICKS > HIGH_TICKS)
                         ? ((LEAD_TICKS > TRAIL_TICKS) ? LEAD_TICKS : TRAIL_TICKS)
                         : ((HIGH_TICKS > TRAIL_TICKS) ? HIGH_TICKS : TRAIL_TICKS);
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] LEAD_LAST  = CNT_W'(LEAD_TICKS - 1);
    localparam logic [CNT_W-1:0] HIGH_LAST  = CNT_W'(HIGH_TICKS - 1);
    localparam logic [CNT_W-1:0] TRAIL_LAST = CNT_W'(TRAIL_TICKS - 1);

    bxp_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic             clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            clk_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= PH_LEAD;
                end
                PH_LEAD: begin
                    if (cnt == LEAD_LAST) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                        clk_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == HIGH_LAST) begin
                        phase <= PH_TRAIL;
                        cnt   <= '0;
                        clk_q <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == TRAIL_LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign idle     = (phase == PH_IDLE);
    assign port_clk = clk_q;
    assign capture  = (phase == PH_TRAIL) && (cnt == TRAIL_LAST);

endmodule

// File: rtl/bxp_dpath.sv
module bxp_dpath
    import bxp_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  bxp_op_e                op,
    input  logic [REG_W-1:0]       reg_idx,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   capture,
    input  logic [DATA_W-1:0]      port_din,
    output logic [REG_W+SUB_W-1:0] port_addr,
    output logic [DATA_W-1:0]      port_dout,
    output logic [DATA_W-1:0]      rdata,
    output logic                   ack
);
    logic [REG_W+SUB_W-1:0] addr_q;
    logic [DATA_W-1:0]      dout_q;
    logic [DATA_W-1:0]      rdata_q;
    logic                   rd_q;
    logic                   ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            dout_q  <= '0;
            rd_q    <= 1'b0;
        end else if (load) begin
            addr_q  <= {reg_idx, sub_offset(op)};
            dout_q  <= wdata;
            rd_q    <= op_is_read(op);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= capture;
            if (capture) rdata_q <= rd_q ? port_din : '0;
        end
    end

    assign port_addr = addr_q;
    assign port_dout = dout_q;
    assign rdata     = rdata_q;
    assign ack       = ack_q;

endmodule

// File: rtl/bxp_master.sv
module bxp_master
    import bxp_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int DATA_W      = 16,
    parameter int LEAD_TICKS  = 5,
    parameter int HIGH_TICKS  = 8,
    parameter int TRAIL_TICKS = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_req,
    input  logic [1:0]               host_op,
    input  logic [REG_W-1:0]         host_reg,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic                     host_ack,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     bx_clk,
    output logic [REG_W+SUB_W-1:0]   bx_addr,
    output logic [DATA_W-1:0]        bx_dout,
    input  logic [DATA_W-1:0]        bx_din
);
    logic idle;
    logic start;
    logic capture;

    assign start = host_req && idle;

    bxp_seq #(
        .LEAD_TICKS (LEAD_TICKS),
        .HIGH_TICKS (HIGH_TICKS),
        .TRAIL_TICKS(TRAIL_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .idle    (idle),
        .port_clk(bx_clk),
        .capture (capture)
    );

    bxp_dpath #(
        .REG_W (REG_W),
        .DATA_W(DATA_W)
    ) u_dpath (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .op       (bxp_op_e'(host_op)),
        .reg_idx  (host_reg),
        .wdata    (host_wdata),
        .capture  (capture),
        .port_din (bx_din),
        .port_addr(bx_addr),
        .port_dout(bx_dout),
        .rdata    (host_rdata),
        .ack      (host_ack)
    );

endmodule

// File: rtl/bxp_master_chk.sv
module bxp_master_chk #(
    parameter int REG_W       = 8,
    parameter int DATA_W      = 16,
    parameter int LEAD_TICKS  = 5,
    parameter int HIGH_TICKS  = 8,
    parameter int TRAIL_TICKS = 20
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bx_clk,
    input logic [REG_W+3:0]     bx_addr,
    input logic [DATA_W-1:0]    bx_dout,
    input logic                 host_ack
);
    logic [15:0] hi_run;
    logic [15:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= bx_clk ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= bx_clk ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
        end
    end

    AST_LEAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(bx_clk) |-> lo_run >= 16'(LEAD_TICKS)); // R2

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(bx_clk) |-> hi_run == 16'(HIGH_TICKS)); // R3

    AST_TRAIL_WIDTH: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> (!bx_clk && lo_run >= 16'(TRAIL_TICKS))); // R4

    AST_OFFSET_LEGAL: assert property (@(posedge clk) disable iff (rst)
        $rose(bx_clk) |-> bx_addr[3:0] inside {4'd0, 4'd9, 4'd10, 4'd11}); // R5

    AST_PORT_HELD: assert property (@(posedge clk) disable iff (rst)
        (bx_clk || $fell(bx_clk)) |-> ($stable(bx_addr) && $stable(bx_dout))); // R6

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack); // R7

endmodule

bind bxp_master bxp_master_chk #(
    .REG_W      (REG_W),
    .DATA_W     (DATA_W),
    .LEAD_TICKS (LEAD_TICKS),
    .HIGH_TICKS (HIGH_TICKS),
    .TRAIL_TICKS(TRAIL_TICKS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bx_clk  (bx_clk),
    .bx_addr (bx_addr),
    .bx_dout (bx_dout),
    .host_ack(host_ack)
);

// File: tb/sim_bxp_master.sv
`timescale 1ns/100ps
module sim_bxp_master;
    localparam int REG_W  = 8;
    localparam int DATA_W = 16;
    localparam int LEAD   = 5;
    localparam int HIGH   = 8;
    localparam int TRAIL  = 20;
    localparam int TOTAL  = LEAD + HIGH + TRAIL;
    localparam int TICK_PS = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              host_req = 1'b0;
    logic [1:0]        host_op = '0;
    logic [REG_W-1:0]  host_reg = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] bx_din = '0;
    logic              host_ack;
    logic [DATA_W-1:0] host_rdata;
    logic              bx_clk;
    logic [REG_W+3:0]  bx_addr;
    logic [DATA_W-1:0] bx_dout;

    bxp_master #(
        .REG_W(REG_W), .DATA_W(DATA_W),
        .LEAD_TICKS(LEAD), .HIGH_TICKS(HIGH), .TRAIL_TICKS(TRAIL)
    ) u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_op(host_op),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .bx_clk(bx_clk), .bx_addr(bx_addr),
        .bx_dout(bx_dout), .bx_din(bx_din)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_off(input int op);
        case (op)
            0: return 4'd0;
            1: return 4'd11;
            2: return 4'd9;
            default: return 4'd10;
        endcase
    endfunction

    // input data changes every tick so the capture edge is pinned exactly
    logic [7:0] din_ctr = '0;
    always @(posedge clk) begin
        #1;
        din_ctr = din_ctr + 8'd1;
        bx_din  = {din_ctr, ~din_ctr};
    end

    // behavioural reference model, advanced on every rising edge
    bit                m_busy = 0;
    int                m_t = 0;
    bit                m_rd = 0;
    logic              m_clk = 0;
    logic              m_ack = 0;
    logic [REG_W+3:0]  m_addr = '0;
    logic [DATA_W-1:0] m_dout = '0;
    logic [DATA_W-1:0] m_rdata = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_t = 0; m_rd = 0; m_clk = 0; m_ack = 0;
            m_addr = '0; m_dout = '0; m_rdata = '0;
        end else begin
            m_ack = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == TOTAL) begin
                    m_busy  = 0;
                    m_ack   = 1;
                    m_rdata = m_rd ? bx_din : '0;
                end
            end else if (host_req) begin
                m_busy = 1;
                m_t    = 0;
                m_addr = {host_reg, ref_off(int'(host_op))};
                m_dout = host_wdata;
                m_rd   = host_op[1];
            end
            m_clk = m_busy && (m_t >= LEAD) && (m_t < LEAD + HIGH);
        end
    end

    // per-cycle comparison and tick-level timing measurement
    logic             p_clk = 0;
    logic             p_ack = 0;
    logic [REG_W+3:0] p_addr = '0;
    logic [DATA_W-1:0] p_dout = '0;
    int addr_age = 0, dout_age = 0, hi_w = 0, lo_w = 0, since_fall = 0;
    int cyc = 0, last_rise = -1;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            string ctag;
            ctag = (m_t < LEAD) ? "R2" : ((m_t < LEAD + HIGH) ? "R3" : "R4");
            chk(bx_clk === m_clk, ctag, "bx_clk", bx_clk, m_clk);
            chk(bx_addr === m_addr, "R5", "bx_addr", bx_addr, m_addr);
            chk(bx_dout === m_dout, "R6", "bx_dout", bx_dout, m_dout);
            chk(host_ack === m_ack, "R7", "host_ack", host_ack, m_ack);
            chk(host_rdata === m_rdata, "R8", "host_rdata", host_rdata, m_rdata);

            addr_age = (bx_addr !== p_addr) ? 0 : addr_age + 1;
            dout_age = (bx_dout !== p_dout) ? 0 : dout_age + 1;
            if (bx_clk && !p_clk) begin
                chk(addr_age * TICK_PS >= 25000, "R2", "addr setup ps", addr_age * TICK_PS, 25000);
                chk(addr_age > 0, "R6", "addr hold at rise", addr_age, 1);
                if (last_rise >= 0)
                    chk((cyc - last_rise) * TICK_PS >= 137000, "R4", "period ps",
                        (cyc - last_rise) * TICK_PS, 137000);
                last_rise = cyc;
            end
            if (!bx_clk && p_clk) begin
                chk(hi_w * TICK_PS >= 39000, "R3", "high ps", hi_w * TICK_PS, 39000);
                chk(dout_age * TICK_PS >= 36000, "R3", "data setup ps", dout_age * TICK_PS, 36000);
                chk(addr_age > 0 && dout_age > 0, "R6", "hold at fall", addr_age, 1);
                since_fall = 0;
            end else begin
                since_fall++;
            end
            if (host_ack && !p_ack)
                chk(since_fall * TICK_PS >= 90000, "R4", "capture after fall ps",
                    since_fall * TICK_PS, 90000);
            hi_w = bx_clk ? hi_w + 1 : 0;
            lo_w = bx_clk ? 0 : lo_w + 1;
        end
        p_clk = bx_clk; p_ack = host_ack; p_addr = bx_addr; p_dout = bx_dout;
    end

    task automatic issue(input logic [1:0] op, input logic [REG_W-1:0] r,
                         input logic [DATA_W-1:0] wd);
        @(posedge clk); #1;
        host_req = 1'b1; host_op = op; host_reg = r; host_wdata = wd;
        @(posedge clk); #1;
        host_req = 1'b0;
    endtask

    task automatic wait_ack();
        for (int i = 0; i < 4 * TOTAL; i++) begin
            @(negedge clk);
            if (host_ack) break;
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk({bx_clk, host_ack} === 2'b00 && bx_addr === '0 && bx_dout === '0
            && host_rdata === '0, "R1", "reset outputs", {bx_clk, bx_addr}, 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk(bx_clk === 1'b0 && bx_addr === '0 && host_ack === 1'b0, "R1",
            "after reset", {bx_clk, bx_addr}, 0);

        // R5 each sub-function, R8 reads and writes
        issue(2'd0, 8'h00, 16'h1234); wait_ack(); repeat (3) @(posedge clk);
        issue(2'd1, 8'hFF, 16'hBEEF); wait_ack(); repeat (2) @(posedge clk);
        issue(2'd2, 8'h5A, 16'h0F0F); wait_ack(); repeat (5) @(posedge clk);
        issue(2'd3, 8'hA5, 16'hFFFF); wait_ack(); repeat (1) @(posedge clk);
        issue(2'd0, 8'h81, 16'h0000); wait_ack(); repeat (4) @(posedge clk);

        // R9: request while busy is ignored
        issue(2'd0, 8'h12, 16'h4444);
        repeat (3) @(posedge clk);
        issue(2'd3, 8'h34, 16'h5555);
        @(negedge clk);
        chk(bx_addr === {8'h12, 4'd0}, "R9", "addr after busy request",
            bx_addr, {8'h12, 4'd0});
        chk(bx_dout === 16'h4444, "R9", "dout after busy request", bx_dout, 16'h4444);
        wait_ack();
        repeat (TOTAL) @(posedge clk);
        @(negedge clk);
        chk(bx_clk === 1'b0 && bx_addr === {8'h12, 4'd0}, "R9",
            "no late start from ignored request", bx_addr, {8'h12, 4'd0});

        // R9: request during acknowledge cycle is accepted back to back
        issue(2'd2, 8'h77, 16'h7777);
        for (int i = 0; i < 4 * TOTAL; i++) begin
            @(negedge clk);
            if (host_ack) break;
        end
        host_req = 1'b1; host_op = 2'd1; host_reg = 8'h78; host_wdata = 16'h8888;
        @(posedge clk); #1; host_req = 1'b0;
        @(negedge clk);
        chk(bx_addr === {8'h78, 4'd11}, "R9", "accept in ack cycle",
            bx_addr, {8'h78, 4'd11});
        wait_ack();
        issue(2'd3, 8'h01, 16'h0001); wait_ack();
        repeat (6) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule